// File: doc/BRIEF.md
# Periodic Reload Timer with Compare

A 32-bit down-counting interrupt timer reached through a simple word-addressed register bus. Software picks one of three tick inputs (or none) and a 12-bit prescaler. Together these produce a count step every (prescaler + 1) selected ticks. At terminal count the counter either reloads from a software-written load value or wraps to all-ones and keeps running freely.

A compare value is checked against the counter on every step. A match latches a status flag. The flag drives a level interrupt when both the compare interrupt enable and the timer enable are set. Software clears the flag by writing a one to it. Two other writes act on the counter directly: a load write with immediate overwrite set loads the counter at once, and setting enable with the start-mode bit loads it from the reload source. A software reset bit clears the counter state and the run-control bits and leaves the other configuration as written.

The bits for wait, doze, stop and debug are stored and read back only. They have no effect on the count.

Top module: `ptmr_top`

## Requirements
- R1: Word offsets are control=0, status=1, load=2, compare=3, count=4 (read-only). Writes to offsets 5..7 change no register, and reads of them return 0. Read data appears on `bus_rdata` one clock after the read request.
- R2: Control bits: 0 enable, 1 start-mode, 2 compare interrupt enable, 3 reload-mode, 15:4 prescaler, 16 software reset, 17 immediate overwrite, 18..21 debug/wait/doze/stop (stored only), 25:24 clock source. Written bits 31:26 are dropped and read back as 0.
- R3: Clock source 0 selects no tick, so the counter holds. Sources 1, 2 and 3 select `tick_i[0]`, `tick_i[1]` and `tick_i[2]`. Ticks on unselected inputs are ignored. One count step occurs every (prescaler+1) selected ticks while enable is set.
- R4: Each step decrements the counter. A step taken at 0 loads the load register when reload-mode is 1, and 0xFFFFFFFF otherwise.
- R5: A control write that raises enable from 0 to 1 with start-mode 1 loads the counter: from the load register if the written reload-mode is 1, else with 0xFFFFFFFF. With start-mode 0 the counter keeps its value.
- R6: A load-register write while immediate overwrite is set also loads the counter with the written value in the same cycle. With it clear, the counter is unchanged.
- R7: A count step taken while the counter equals the compare value sets status bit 0. With compare 0, this is the terminal-count step.
- R8: `irq_o` is a register that equals (status bit 0 AND compare interrupt enable AND enable) as they stood one clock earlier.
- R9: Writing status with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it unchanged. A match in the same cycle wins over the clear.
- R10: A control write with bit 16 set clears bits 0, 1 and 18..21 and keeps the other written bits. It also clears status, compare and counter, and sets the load register to 0xFFFFFFFF. Bit 16 clears itself on the next clock.
- R11: Synchronous reset clears all registers, the read data and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_i | input | 3 | One tick-enable input per clock source 1..3 |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest cases to reach are the exact step on which the compare flag fires and the counter value just after a terminal-count wrap. Both depend on the prescaler phase and on which write started the count. The bench sweeps prescaler 0..3, load 1..4 and every compare value from 0 to the load value. For each combination it counts clocks from the enabling write to the first interrupt and compares the count with (load - compare + 1)·(prescaler + 1) + 1. It reaches wrap states by freezing the counter with source 0, preloading a small value through immediate overwrite, and then letting an exact number of steps run before freezing it again for readback.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int ADDR_W = 3;
  localparam int PRE_W  = 12;
  localparam int SEL_W  = 2;
  localparam int SRC_N  = (1 << SEL_W) - 1;
  localparam int CTRL_W = 26;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 3'd4;

  localparam int B_EN     = 0;
  localparam int B_START  = 1;
  localparam int B_CIE    = 2;
  localparam int B_RLD    = 3;
  localparam int B_PRE    = 4;
  localparam int B_SRST   = 16;
  localparam int B_OVW    = 17;
  localparam int B_DBG    = 18;
  localparam int B_WAIT   = 19;
  localparam int B_DOZE   = 20;
  localparam int B_STOP   = 21;
  localparam int B_SRC    = 24;

  localparam logic [CTRL_W-1:0] SRST_DROP =
    CTRL_W'((1 << B_EN) | (1 << B_START) | (1 << B_DBG) |
            (1 << B_WAIT) | (1 << B_DOZE) | (1 << B_STOP));
endpackage

// File: rtl/ptmr_tick_gen.sv
module ptmr_tick_gen
  import ptmr_pkg::*;
#(
  parameter int PW = PRE_W,
  parameter int SW = SEL_W,
  localparam int NS = (1 << SW) - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [SW-1:0] sel,
  input  logic [PW-1:0] pre,
  input  logic [NS-1:0] tick_i,
  output logic          step
);
  logic          src_tick;
  logic [PW-1:0] div_q;

  always_comb begin
    src_tick = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (sel == SW'(i + 1)) src_tick = tick_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
    end else if (src_tick) begin
      if (div_q >= pre) div_q <= '0;
      else              div_q <= div_q + 1'b1;
    end
  end

  assign step = run && src_tick && (div_q >= pre);
endmodule

// File: rtl/ptmr_down_cnt.sv
module ptmr_down_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         force_en,
  input  logic [W-1:0] force_val,
  input  logic         step,
  input  logic         rld_mode,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst || clr)         cnt_q <= '0;
    else if (force_en)      cnt_q <= force_val;
    else if (step) begin
      if (cnt_q == '0)      cnt_q <= rld_mode ? load_val : {W{1'b1}};
      else                  cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4
  wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_q == '0 && !force_en && !clr) |=>
      (cnt_q == ($past(rld_mode) ? $past(load_val) : {W{1'b1}})));
endmodule

// File: rtl/ptmr_cmp_flag.sv
module ptmr_cmp_flag #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         ack,
  output logic         flag_q
);
  logic hit;
  assign hit = step && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst || clr) flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (ack)   flag_q <= 1'b0;
  end

  // R7
  match_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (step && cnt == cmp && !clr) |=> flag_q);

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !(step && cnt == cmp) && !clr) |=> !flag_q);
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SRC_N-1:0]  tick_i,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] load_q, cmp_q, cnt_q, rdata_q;
  logic              flag_q, irq_q, step;
  logic              wr, ctrl_wr, stat_wr, load_wr, cmp_wr, srst_wr;
  logic              cnt_force;
  logic [DATA_W-1:0] force_val;
  logic [CTRL_W-1:0] wctrl;

  assign wr      = bus_sel && bus_we;
  assign ctrl_wr = wr && bus_addr == OFS_CTRL;
  assign stat_wr = wr && bus_addr == OFS_STAT;
  assign load_wr = wr && bus_addr == OFS_LOAD;
  assign cmp_wr  = wr && bus_addr == OFS_CMP;
  assign wctrl   = bus_wdata[CTRL_W-1:0];
  assign srst_wr = ctrl_wr && wctrl[B_SRST];

  // control register: soft reset drops run-control bits, its own bit self-clears
  always_ff @(posedge clk) begin
    if (rst)                    ctrl_q <= '0;
    else if (ctrl_wr && srst_wr) ctrl_q <= wctrl & ~SRST_DROP;
    else if (ctrl_wr)           ctrl_q <= wctrl;
    else                        ctrl_q[B_SRST] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          load_q <= '0;
    else if (srst_wr) load_q <= '1;
    else if (load_wr) load_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || srst_wr) cmp_q <= '0;
    else if (cmp_wr)    cmp_q <= bus_wdata;
  end

  // counter preload sources: enable rising edge with start-mode, or overwrite
  always_comb begin
    cnt_force = 1'b0;
    force_val = '0;
    if (ctrl_wr && !srst_wr && wctrl[B_EN] && !ctrl_q[B_EN] && wctrl[B_START]) begin
      cnt_force = 1'b1;
      force_val = wctrl[B_RLD] ? load_q : '1;
    end else if (load_wr && ctrl_q[B_OVW]) begin
      cnt_force = 1'b1;
      force_val = bus_wdata;
    end
  end

  ptmr_tick_gen #(.PW(PRE_W), .SW(SEL_W)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .run    (ctrl_q[B_EN]),
    .sel    (ctrl_q[B_SRC +: SEL_W]),
    .pre    (ctrl_q[B_PRE +: PRE_W]),
    .tick_i (tick_i),
    .step   (step)
  );

  ptmr_down_cnt #(.W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clr       (srst_wr),
    .force_en  (cnt_force),
    .force_val (force_val),
    .step      (step),
    .rld_mode  (ctrl_q[B_RLD]),
    .load_val  (load_q),
    .cnt_q     (cnt_q)
  );

  ptmr_cmp_flag #(.W(DATA_W)) u_flag (
    .clk    (clk),
    .rst    (rst),
    .clr    (srst_wr),
    .step   (step),
    .cnt    (cnt_q),
    .cmp    (cmp_q),
    .ack    (stat_wr && bus_wdata[0]),
    .flag_q (flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag_q && ctrl_q[B_CIE] && ctrl_q[B_EN];
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_sel || bus_we) begin
      rdata_q <= '0;
    end else begin
      case (bus_addr)
        OFS_CTRL: rdata_q <= DATA_W'(ctrl_q);
        OFS_STAT: rdata_q <= DATA_W'(flag_q);
        OFS_LOAD: rdata_q <= load_q;
        OFS_CMP:  rdata_q <= cmp_q;
        OFS_CNT:  rdata_q <= cnt_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  // R3
  no_src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[B_SRC +: SEL_W] == '0 && !cnt_force && !srst_wr) |=> $stable(cnt_q));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(flag_q && ctrl_q[B_CIE] && ctrl_q[B_EN]));

  // R10
  srst_self_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[B_SRST] |=> !ctrl_q[B_SRST]);

  // R10
  srst_state_chk: assert property (@(posedge clk) disable iff (rst)
    srst_wr |=> (load_q == '1 && cmp_q == '0 && cnt_q == '0 && !flag_q));
endmodule

// File: tb/ptmr_top_tb_top.sv
module ptmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  tick = 3'b111;
  logic        irq;
  int          errs = 0, checks = 0;
  bit          done = 1'b0;

  localparam logic [31:0] EN = 32'h1, ST = 32'h2, CIE = 32'h4, RLD = 32'h8;
  localparam logic [31:0] SRST = 32'h1_0000, OVW = 32'h2_0000;

  always #5 clk = ~clk;

  ptmr_top dut_i (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .tick_i(tick), .irq_o(irq)
  );

  function automatic logic [31:0] src(input int s);
    return 32'(s) << 24;
  endfunction

  function automatic logic [31:0] pre(input int p);
    return 32'(p) << 4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); #1;
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, vexp;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R11: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R11 reg after reset", v, 32'h0);
    end
    chk("R11 irq after reset", {31'b0, irq}, 32'h0);

    // R7 / R8 / R3: sweep of prescaler, load and compare
    for (int p = 0; p < 4; p++) begin
      for (int l = 1; l < 5; l++) begin
        for (int c = 0; c <= l; c++) begin
          int n, expn;
          wr(3'd0, SRST);
          wr(3'd2, 32'(l));
          wr(3'd3, 32'(c));
          wr(3'd0, EN | ST | CIE | RLD | pre(p) | src(1));
          n = 0;
          while (irq !== 1'b1 && n < 200) begin
            @(posedge clk); #1;
            n++;
          end
          expn = (l - c + 1) * (p + 1) + 1;
          chk($sformatf("R7 first irq cycle p=%0d l=%0d c=%0d", p, l, c), 32'(n), 32'(expn));
        end
      end
    end

    // freeze counting, flag still set
    wr(3'd0, EN | ST | CIE | RLD | src(0));
    wr(3'd1, 32'h0);
    idle(2);
    chk("R9 write 0 keeps irq", {31'b0, irq}, 32'h1);
    wr(3'd0, EN | RLD | src(0));
    idle(2);
    chk("R8 irq gated by interrupt enable", {31'b0, irq}, 32'h0);
    rd(3'd1, v);
    chk("R8 status still set", v, 32'h1);
    wr(3'd0, EN | CIE | RLD | src(0));
    idle(2);
    chk("R8 irq back with enable", {31'b0, irq}, 32'h1);
    wr(3'd1, 32'h1);
    idle(2);
    chk("R9 irq after clear", {31'b0, irq}, 32'h0);
    rd(3'd1, v);
    chk("R9 status after clear", v, 32'h0);

    // R10 / R2: software reset
    wr(3'd3, 32'd3);
    v = 32'h1000_0000 | src(3) | 32'h003C_0000 | OVW | SRST | pre(5) | RLD | CIE | ST | EN;
    wr(3'd0, v);
    idle(1);
    vexp = v & 32'h03FF_FFFF & ~(EN | ST | 32'h003C_0000 | SRST);
    rd(3'd0, v);
    chk("R10 R2 control after soft reset", v, vexp);
    rd(3'd2, v); chk("R10 load after soft reset", v, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R10 compare after soft reset", v, 32'h0);
    rd(3'd4, v); chk("R10 count after soft reset", v, 32'h0);
    rd(3'd1, v); chk("R10 status after soft reset", v, 32'h0);

    // R5: start-mode behaviour
    wr(3'd0, 32'h0);
    wr(3'd2, 32'd5);
    rd(3'd4, v); chk("R6 no overwrite when bit clear", v, 32'h0);
    wr(3'd0, EN | ST | RLD | src(0));
    rd(3'd4, v); chk("R5 start loads from load reg", v, 32'd5);
    wr(3'd0, 32'h0);
    wr(3'd0, EN | ST | src(0));
    rd(3'd4, v); chk("R5 start loads all-ones", v, 32'hFFFF_FFFF);
    wr(3'd0, 32'h0);
    wr(3'd0, EN | src(0));
    rd(3'd4, v); chk("R5 no start-mode keeps count", v, 32'hFFFF_FFFF);
    idle(4);
    rd(3'd4, v); chk("R3 source 0 holds", v, 32'hFFFF_FFFF);
    wr(3'd2, 32'd9);
    rd(3'd4, v); chk("R6 load write without overwrite", v, 32'hFFFF_FFFF);

    // R6 / R4: free-running wrap
    wr(3'd0, EN | OVW | src(0));
    wr(3'd2, 32'd2);
    rd(3'd4, v); chk("R6 overwrite loads counter", v, 32'd2);
    wr(3'd0, EN | OVW | src(1));
    idle(3);
    wr(3'd0, EN | OVW | src(0));
    rd(3'd4, v); chk("R4 free-run wrap to all-ones", v, 32'hFFFF_FFFE);

    // R4: reload wrap
    wr(3'd0, EN | OVW | RLD | src(0));
    wr(3'd2, 32'd2);
    wr(3'd0, EN | OVW | RLD | src(1));
    idle(3);
    wr(3'd0, EN | OVW | RLD | src(0));
    rd(3'd4, v); chk("R4 reload at terminal count", v, 32'd1);

    // R3: source selection
    tick = 3'b001;
    wr(3'd0, EN | RLD | src(2));
    idle(4);
    wr(3'd0, EN | RLD | src(0));
    rd(3'd4, v); chk("R3 unselected tick ignored", v, 32'd1);
    tick = 3'b100;
    wr(3'd0, EN | RLD | src(3));
    idle(1);
    wr(3'd0, EN | RLD | src(0));
    rd(3'd4, v); chk("R3 source 3 steps", v, 32'd2);
    tick = 3'b111;

    // R1: unused offsets
    wr(3'd5, 32'h1234);
    wr(3'd7, 32'h5678);
    rd(3'd2, v); chk("R1 load untouched by bad offset", v, 32'd2);
    rd(3'd3, v); chk("R1 compare untouched by bad offset", v, 32'd0);
    rd(3'd5, v); chk("R1 read offset 5", v, 32'h0);
    rd(3'd7, v); chk("R1 read offset 7", v, 32'h0);

    finish_run();
  end
endmodule